// File: doc/BRIEF.md
# Codec Command Ring Fetch Engine

This block feeds a codec link with 32-bit command words. Host software places the words in a ring of memory and advances a write pointer. The engine then reads one word at a time over a simple memory read port, splits it into its fields and hands it to the codec link with a valid/ready handshake. A single immediate command can also be posted through a register. That command goes out ahead of any ring traffic.

The read pointer is advanced before each read, so it always names the last word consumed. The memory address is the 64-bit ring base plus four times the new pointer value. The loop keeps fetching while three things hold: the run bit is set, the ring is not empty, and the response side does not signal that its response quota has been reached. When any of these fails, the loop goes to sleep. Only a restart event wakes it again: a write to the write pointer, a write to the control register, a posted immediate command, or a pulse reporting that the response interrupt status was cleared.

Top module: `cmdring_fetch`

## Requirements
- R1: After reset the read pointer is 0, the immediate-busy flag is 0, and neither the memory request nor the command output is valid.
- R2: Writing the immediate register (select 5) while the immediate-busy flag is clear sets the flag. The word it holds is handed off before any ring word is fetched, whether or not the run bit is set, and the flag clears once that word is handed off or rejected.
- R3: While the run bit (bit 0 of a control write, select 3) is clear, no ring word is fetched and the read pointer does not move.
- R4: When the read pointer equals the write pointer (select 2, low 8 bits), the ring is empty and nothing is fetched, so draining stops with the read pointer equal to the write pointer.
- R5: While rsp_stall is high, no fetch starts. Lowering rsp_stall alone does not resume fetching.
- R6: Each fetch first advances the read pointer by one modulo 256, wrapping from 255 to 0. It then requests the word at base + 4 × pointer, where the base is {high word (select 1), low word (select 0)}. The read pointer can be loaded through select 4.
- R7: An accepted word is forwarded as codec address = bits 31:28, node id = bits 26:20 and payload = bits 19:0, in fetch order.
- R8: A word with bit 27 set is discarded and not forwarded. This applies to ring words and to immediate words.
- R9: A word whose codec address has its bit clear in codec_present is discarded and not forwarded.
- R10: A sleeping loop resumes after a write-pointer write, a control write or an rsp_ack_clr pulse. The first request is valid one clock edge after the edge that takes the write.
- R11: At most one memory read is outstanding. A pending request holds its address until it is accepted, a pending command holds its fields until it is accepted, and the engine becomes idle only after the handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base low, 1 base high, 2 write pointer, 3 control, 4 read pointer, 5 immediate |
| reg_wdata | input | 32 | Register write data |
| rd_ptr | output | 8 | Current read pointer |
| imm_busy | output | 1 | Immediate command pending |
| rsp_stall | input | 1 | Response quota reached; blocks new fetches |
| rsp_ack_clr | input | 1 | Pulse: response interrupt status cleared (restart) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | 64 | Byte address of the requested word |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| codec_present | input | 16 | One bit per codec address that has a codec attached |
| cmd_valid | output | 1 | Command valid toward the codec link |
| cmd_ready | input | 1 | Codec link accepts the command |
| cmd_cad | output | 4 | Codec address |
| cmd_nid | output | 7 | Node id |
| cmd_payload | output | 20 | Command payload |

## Verification
A restart write taken at one edge produces a valid request, with the pointer already advanced, one edge later. The bench samples that state at the falling edge that follows. Read data is returned on the falling edge after the request is accepted, and the decoded command is valid after the next rising edge. The bench does not pin down when later commands appear. It predicts each accepted word, together with the address and pointer value, at the falling edge before the request handshake, and it compares each command at the falling edge before its handshake. Checks that something stalled or was ignored wait twenty or more idle cycles before reading the pointer, so that any wrongly started fetch would already have shown up.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
   localparam int CMD_W   = 32;
   localparam int CAD_W   = 4;
   localparam int CAD_LSB = 28;
   localparam int IND_BIT = 27;
   localparam int NID_W   = 7;
   localparam int NID_LSB = 20;
   localparam int PAY_W   = 20;
   localparam int RUN_BIT = 0;

   localparam logic [2:0] SEL_BASE_LO = 3'd0;
   localparam logic [2:0] SEL_BASE_HI = 3'd1;
   localparam logic [2:0] SEL_WR_PTR  = 3'd2;
   localparam logic [2:0] SEL_CTRL    = 3'd3;
   localparam logic [2:0] SEL_RD_PTR  = 3'd4;
   localparam logic [2:0] SEL_IMM     = 3'd5;

   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_SEND} fetch_st_e;

   typedef struct packed {
      logic [CAD_W-1:0] cad;
      logic [NID_W-1:0] nid;
      logic [PAY_W-1:0] pay;
   } codec_cmd_t;
endpackage

// File: rtl/cmdring_verb_dec.sv
module cmdring_verb_dec
   import cmdring_pkg::*;
#(
   parameter int NUM_CODECS = 16
) (
   input  logic [CMD_W-1:0]      word,
   input  logic [NUM_CODECS-1:0] present,
   output codec_cmd_t            cmd,
   output logic                  accept
);
   localparam int NUM_ADDR = 1 << CAD_W;

   if (NUM_CODECS < 1 || NUM_CODECS > NUM_ADDR) begin : g_bad_codecs
      $error("cmdring_verb_dec: NUM_CODECS out of range");
   end

   logic [NUM_ADDR-1:0] attached;

   // Map the presence vector onto the full codec address space.
   for (genvar g = 0; g < NUM_ADDR; g++) begin : g_map
      if (g < NUM_CODECS) begin : g_on
         assign attached[g] = present[g];
      end else begin : g_off
         assign attached[g] = 1'b0;
      end
   end

   assign cmd.cad = word[CAD_LSB +: CAD_W];
   assign cmd.nid = word[NID_LSB +: NID_W];
   assign cmd.pay = word[PAY_W-1:0];

   // Indirect-addressed words and words aimed at empty slots are refused.
   assign accept = !word[IND_BIT] && attached[cmd.cad];
endmodule

// File: rtl/cmdring_ptr.sv
module cmdring_ptr #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wp_we,
   input  logic             rp_we,
   input  logic [PTR_W-1:0] wdata,
   input  logic             adv,
   output logic [PTR_W-1:0] rp,
   output logic [PTR_W-1:0] wp,
   output logic [PTR_W-1:0] rp_next,
   output logic             empty
);
   localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

   assign rp_next = rp + ONE;   // wraps modulo 2**PTR_W
   assign empty   = (rp == wp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp <= '0;
         wp <= '0;
      end else begin
         if (wp_we) wp <= wdata;
         // an advance wins over a software load in the same cycle
         if (adv)        rp <= rp_next;
         else if (rp_we) rp <= wdata;
      end
   end
endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
   import cmdring_pkg::*;
#(
   parameter int PTR_W      = 8,
   parameter int ADDR_W     = 64,
   parameter int NUM_CODECS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [2:0]            reg_sel,
   input  logic [31:0]           reg_wdata,
   output logic [PTR_W-1:0]      rd_ptr,
   output logic                  imm_busy,
   input  logic                  rsp_stall,
   input  logic                  rsp_ack_clr,
   output logic                  mem_req_valid,
   output logic [ADDR_W-1:0]     mem_req_addr,
   input  logic                  mem_req_ready,
   input  logic                  mem_rsp_valid,
   input  logic [CMD_W-1:0]      mem_rsp_data,
   input  logic [NUM_CODECS-1:0] codec_present,
   output logic                  cmd_valid,
   input  logic                  cmd_ready,
   output logic [CAD_W-1:0]      cmd_cad,
   output logic [NID_W-1:0]      cmd_nid,
   output logic [PAY_W-1:0]      cmd_payload
);
   localparam int HI_W  = ADDR_W - 32;
   localparam int PAD_W = ADDR_W - PTR_W - 2;

   if (PTR_W < 2 || PTR_W > 16) begin : g_bad_ptr
      $error("cmdring_fetch: PTR_W out of range");
   end
   if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr
      $error("cmdring_fetch: ADDR_W out of range");
   end

   fetch_st_e         st;
   logic [31:0]       base_lo_q;
   logic [HI_W-1:0]   base_hi_q;
   logic [ADDR_W-1:0] base_q;
   logic              run_q, go_q, from_imm_q;
   logic [CMD_W-1:0]  imm_word_q;
   logic [ADDR_W-1:0] addr_q;
   codec_cmd_t        cmd_q;

   logic [PTR_W-1:0]  wr_ptr, rp_next;
   logic              ring_empty, fetch_ok, trig;
   logic              lo_we, hi_we, wp_we, ctl_we, rp_we, imm_we;
   logic [CMD_W-1:0]  dec_word;
   codec_cmd_t        dec_cmd;
   logic              dec_ok;

   assign lo_we  = reg_we && (reg_sel == SEL_BASE_LO);
   assign hi_we  = reg_we && (reg_sel == SEL_BASE_HI);
   assign wp_we  = reg_we && (reg_sel == SEL_WR_PTR);
   assign ctl_we = reg_we && (reg_sel == SEL_CTRL);
   assign rp_we  = reg_we && (reg_sel == SEL_RD_PTR);
   assign imm_we = reg_we && (reg_sel == SEL_IMM) && !imm_busy;
   assign trig   = wp_we || ctl_we || imm_we || rsp_ack_clr;

   assign base_q   = {base_hi_q, base_lo_q};
   assign fetch_ok = go_q && (st == ST_IDLE) && !imm_busy && run_q
                     && !ring_empty && !rsp_stall;

   // One decoder serves both sources: the immediate word while idle, read data otherwise.
   assign dec_word = (st == ST_IDLE) ? imm_word_q : mem_rsp_data;

   cmdring_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wp_we   (wp_we),
      .rp_we   (rp_we),
      .wdata   (reg_wdata[PTR_W-1:0]),
      .adv     (fetch_ok),
      .rp      (rd_ptr),
      .wp      (wr_ptr),
      .rp_next (rp_next),
      .empty   (ring_empty)
   );

   cmdring_verb_dec #(.NUM_CODECS(NUM_CODECS)) u_dec (
      .word    (dec_word),
      .present (codec_present),
      .cmd     (dec_cmd),
      .accept  (dec_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         base_lo_q  <= '0;
         base_hi_q  <= '0;
         run_q      <= 1'b0;
         go_q       <= 1'b0;
         imm_busy   <= 1'b0;
         imm_word_q <= '0;
         from_imm_q <= 1'b0;
         addr_q     <= '0;
         cmd_q      <= '0;
      end else begin
         if (lo_we)  base_lo_q <= reg_wdata;
         if (hi_we)  base_hi_q <= reg_wdata[HI_W-1:0];
         if (ctl_we) run_q     <= reg_wdata[RUN_BIT];
         if (imm_we) begin
            imm_word_q <= reg_wdata;
            imm_busy   <= 1'b1;
         end
         if (trig) go_q <= 1'b1;

         unique case (st)
            ST_IDLE: begin
               if (go_q) begin
                  if (imm_busy) begin
                     if (dec_ok) begin
                        cmd_q      <= dec_cmd;
                        from_imm_q <= 1'b1;
                        st         <= ST_SEND;
                     end else begin
                        imm_busy <= 1'b0;
                     end
                  end else if (fetch_ok) begin
                     addr_q <= base_q + {{PAD_W{1'b0}}, rp_next, 2'b00};
                     st     <= ST_REQ;
                  end else if (!trig) begin
                     go_q <= 1'b0;   // loop sleeps until the next restart event
                  end
               end
            end
            ST_REQ: begin
               if (mem_req_ready) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  from_imm_q <= 1'b0;
                  if (dec_ok) begin
                     cmd_q <= dec_cmd;
                     st    <= ST_SEND;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_SEND: begin
               if (cmd_ready) begin
                  st <= ST_IDLE;
                  if (from_imm_q) imm_busy <= 1'b0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (st == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign cmd_valid     = (st == ST_SEND);
   assign cmd_cad       = cmd_q.cad;
   assign cmd_nid       = cmd_q.nid;
   assign cmd_payload   = cmd_q.pay;
endmodule

// File: rtl/cmdring_fetch_chk.sv
module cmdring_fetch_chk #(
   parameter int PTR_W  = 8,
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [ADDR_W-1:0] base,
   input logic [PTR_W-1:0]  rd_ptr,
   input logic [PTR_W-1:0]  wr_ptr,
   input logic              run,
   input logic              rsp_stall,
   input logic              imm_busy,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [30:0]       cmd_bits
);
   logic [ADDR_W-1:0] ptr_off;
   assign ptr_off = {{(ADDR_W-PTR_W-2){1'b0}}, rd_ptr, 2'b00};

   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_bits));

   a_r3_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> $past(run));

   a_r4_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> $past(rd_ptr) != $past(wr_ptr));

   a_r5_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> !$past(rsp_stall));

   a_r2_imm_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> !$past(imm_busy));

   a_r6_pre_incr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> rd_ptr == $past(rd_ptr) + 1'b1);

   a_r6_address: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> mem_req_addr == $past(base) + ptr_off);
endmodule

bind cmdring_fetch cmdring_fetch_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .base          (base_q),
   .rd_ptr        (rd_ptr),
   .wr_ptr        (wr_ptr),
   .run           (run_q),
   .rsp_stall     (rsp_stall),
   .imm_busy      (imm_busy),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_bits      ({cmd_cad, cmd_nid, cmd_payload})
);

// File: tb/cmdring_fetch_bench.sv
`timescale 1ns/1ps
module cmdring_fetch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [7:0]  rd_ptr;
   logic        imm_busy;
   logic        rsp_stall = 1'b0;
   logic        rsp_ack_clr = 1'b0;
   logic        mem_req_valid;
   logic [63:0] mem_req_addr;
   logic        mem_rdy = 1'b1;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic [15:0] codec_present = 16'h000F;
   logic        cmd_valid;
   logic        cmd_rdy = 1'b1;
   logic [3:0]  cmd_cad;
   logic [6:0]  cmd_nid;
   logic [19:0] cmd_payload;

   int  checks = 0;
   int  errors = 0;
   int  cyc = 0;
   int  model_rp = 0;
   bit  done = 1'b0;
   bit  bp = 1'b0;
   bit  rsp_pend = 1'b0;
   logic [63:0] base = 64'h0000_0012_3456_7800;
   logic [30:0] exp_q[$];

   cmdring_fetch u_cmdring_fetch (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .rd_ptr(rd_ptr), .imm_busy(imm_busy),
      .rsp_stall(rsp_stall), .rsp_ack_clr(rsp_ack_clr),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_rdy),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .codec_present(codec_present),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_rdy),
      .cmd_cad(cmd_cad), .cmd_nid(cmd_nid), .cmd_payload(cmd_payload)
   );

   // Ring contents: word i of the host ring.
   function automatic logic [31:0] ring_word(int i);
      logic [31:0] w;
      w = {4'(i % 4), 1'b0, 7'((i * 5) % 128), 20'(i * 977 + 3)};
      if (i == 3)   w[27] = 1'b1;          // indirect addressing, refused
      if (i == 5)   w[31:28] = 4'd9;       // no codec attached
      if (i == 252) w[31:28] = 4'd14;      // no codec attached
      return w;
   endfunction

   function automatic bit accepted(logic [31:0] w);
      return !w[27] && codec_present[w[31:28]];
   endfunction

   function automatic logic [30:0] fields(logic [31:0] w);
      return {w[31:28], w[26:20], w[19:0]};
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // Reference model and monitors, evaluated away from the active edge.
   always @(negedge clk) begin
      logic [30:0] e;
      cyc++;
      if (bp) begin
         mem_rdy = (cyc % 3) != 0;
         cmd_rdy = (cyc % 4) >= 2;
      end else begin
         mem_rdy = 1'b1;
         cmd_rdy = 1'b1;
      end
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = ring_word(model_rp);
         rsp_pend      = 1'b0;
      end
      if (rst_n && mem_req_valid && mem_rdy) begin
         model_rp = (model_rp + 1) % 256;
         // R6: pointer already advanced, address from base and new pointer
         check(rd_ptr == 8'(model_rp), "R6", "read pointer at request", rd_ptr, model_rp);
         check(mem_req_addr == base + 64'(4 * model_rp), "R6", "request address",
               mem_req_addr, base + 64'(4 * model_rp));
         if (accepted(ring_word(model_rp))) exp_q.push_back(fields(ring_word(model_rp)));
         rsp_pend = 1'b1;
      end
      if (rst_n && cmd_valid && cmd_rdy) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 R8 R9", "unexpected command", {cmd_cad, cmd_nid, cmd_payload}, 0);
         end else begin
            e = exp_q.pop_front();
            check({cmd_cad, cmd_nid, cmd_payload} == e, "R7 R8 R9", "command fields",
                  {cmd_cad, cmd_nid, cmd_payload}, e);
         end
      end
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      idle(3);
      // R1: reset state
      check(rd_ptr == 0, "R1", "read pointer in reset", rd_ptr, 0);
      check(imm_busy == 0, "R1", "busy in reset", imm_busy, 0);
      check(!mem_req_valid && !cmd_valid, "R1", "valids in reset", {mem_req_valid, cmd_valid}, 0);
      rst_n = 1'b1;
      idle(2);
      check(!mem_req_valid && rd_ptr == 0, "R1", "quiet after reset", {mem_req_valid, rd_ptr}, 0);

      wr(3'd0, base[31:0]);
      wr(3'd1, base[63:32]);
      wr(3'd3, 32'd1);                 // run with empty ring
      wr(3'd2, 32'd8);
      @(negedge clk);
      // R10: request due one edge after the write edge
      check(mem_req_valid && rd_ptr == 8'd1, "R10", "first request timing",
            {mem_req_valid, rd_ptr}, {1'b1, 8'd1});
      idle(60);
      check(exp_q.size() == 0, "R7", "commands left after drain", exp_q.size(), 0);
      check(rd_ptr == 8'd8, "R4", "stops at write pointer", rd_ptr, 8);

      // R3: run clear blocks fetching
      wr(3'd3, 32'd0);
      wr(3'd2, 32'd12);
      idle(20);
      check(rd_ptr == 8'd8, "R3", "no fetch while stopped", rd_ptr, 8);
      wr(3'd3, 32'd1);                 // R10: control write restarts
      idle(60);
      check(rd_ptr == 8'd12, "R10", "resume after control write", rd_ptr, 12);
      check(exp_q.size() == 0, "R10", "commands left", exp_q.size(), 0);

      // R5: stall blocks, dropping it alone does not resume
      rsp_stall = 1'b1;
      wr(3'd2, 32'd15);
      idle(20);
      check(rd_ptr == 8'd12, "R5", "no fetch while stalled", rd_ptr, 12);
      rsp_stall = 1'b0;
      idle(20);
      check(rd_ptr == 8'd12, "R5", "no self restart", rd_ptr, 12);
      @(negedge clk); rsp_ack_clr = 1'b1;
      @(negedge clk); rsp_ack_clr = 1'b0;
      idle(60);
      check(rd_ptr == 8'd15, "R10", "resume after status clear", rd_ptr, 15);

      // R2: immediate command ahead of ring work
      wr(3'd3, 32'd0);
      wr(3'd2, 32'd20);
      w = {4'd2, 1'b0, 7'h11, 20'hABCDE};
      exp_q.push_back(fields(w));
      wr(3'd5, w);
      check(imm_busy == 1'b1, "R2", "busy after immediate write", imm_busy, 1);
      wr(3'd3, 32'd1);
      idle(80);
      check(imm_busy == 1'b0, "R2", "busy cleared", imm_busy, 0);
      check(rd_ptr == 8'd20, "R2", "ring drained after immediate", rd_ptr, 20);
      check(exp_q.size() == 0, "R2", "commands left", exp_q.size(), 0);

      // R8 / R9 on immediate words: dropped, busy clears
      wr(3'd5, {4'd1, 1'b1, 7'h22, 20'h12345});
      idle(10);
      check(imm_busy == 1'b0, "R8", "indirect immediate dropped", imm_busy, 0);
      wr(3'd5, {4'd12, 1'b0, 7'h22, 20'h12345});
      idle(10);
      check(imm_busy == 1'b0, "R9", "absent codec immediate dropped", imm_busy, 0);

      // R6 wrap and R11 under backpressure
      bp = 1'b1;
      wr(3'd3, 32'd0);
      model_rp = 250;
      wr(3'd4, 32'd250);
      check(rd_ptr == 8'd250, "R6", "pointer load", rd_ptr, 250);
      wr(3'd3, 32'd1);
      wr(3'd2, 32'd3);
      idle(300);
      check(rd_ptr == 8'd3, "R6", "wrap to write pointer", rd_ptr, 3);
      check(exp_q.size() == 0, "R11", "commands left under backpressure", exp_q.size(), 0);
      bp = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule